// File: doc/BRIEF.md
# Serial command frame receiver

This block takes 16-bit command frames from a three-wire serial link (data, shift clock, active-low enable) and converts each one into a 4-bit address, a 12-bit payload and a decoded command type. When enable returns high after exactly sixteen shift-clock rising edges, a one-cycle load strobe is raised with those fields. Downstream logic uses the strobe to update a converter channel, the parallel output latch or the port direction register.

All three serial pins are sampled in a single system-clock domain. Each pin passes through a two-flop synchroniser, and the edges are detected afterwards, so the system clock must run at least four times faster than the shift clock. The serial output is driven from the far end of the shift register. Any number of these blocks can therefore be chained, and the previous frame, or port values captured on request, can be read back while the next frame is shifted in.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset `load_o` is 0 and `sdo_o` is 0. The shift register clears to all zeros.
- R2: While enable is low, each rising shift-clock edge samples one bit. The first bit sampled becomes word bit 0 and the sixteenth becomes bit 15.
- R3: Enable rising after exactly 16 bits raises `load_o`, with `addr_o` = word bits 3..0 and `data_o` = word bits 15..4.
- R4: `cmd_o` encoding: address 0..11 gives 0 (converter channel), 13 gives 1 (parallel output write), 14 gives 2 (parallel input capture), 15 gives 3 (direction setup).
- R5: Address 12 is a no-operation. It produces no `load_o`.
- R6: A frame that ends after any bit count other than 16 produces no `load_o`. The bit count restarts at the next frame, so a following valid frame is accepted.
- R7: `sdo_o` shows word bit 0 and advances by one bit on each sampled shift edge. During a frame the previous word therefore leaves in the order bit 0 to bit 15.
- R8: A valid capture frame (address 14) loads `par_i` into word bits 15..4 and keeps bits 3..0. That data leaves on `sdo_o` during the next frame.
- R9: Shift-clock edges while enable is high have no effect on the shift register or on `sdo_o`.
- R10: `load_o` lasts exactly one system clock cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | Serial shift clock |
| sen_ni | input | 1 | Active-low frame enable |
| par_i | input | 12 | Parallel port sample for capture |
| sdo_o | output | 1 | Serial data out (cascade/readback) |
| load_o | output | 1 | One-cycle frame load strobe |
| cmd_o | output | 3 | Decoded command type |
| addr_o | output | 4 | Frame address field |
| data_o | output | 12 | Frame data field |

## Verification
The hardest case to reach is the readback path. It only becomes visible one frame after a capture command, on the serial output, and only if the bit order and the preserved low nibble are both correct. The stimulus sends a capture frame while a known pattern is on the parallel port. It then sends another frame and compares every serial output bit sampled before each shift edge against a bench model of the register. Aborted frames of 10 and 20 bits, and clock pulses while enable is high, are placed directly before valid frames to show that the counter restarts and that stray edges leave the register alone.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = FRAME_W - ADDR_W;
  localparam int NUM_DAC = 12;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam logic [ADDR_W-1:0] CODE_NOP  = 4'd12;
  localparam logic [ADDR_W-1:0] CODE_PWR  = 4'd13;
  localparam logic [ADDR_W-1:0] CODE_PRD  = 4'd14;
  localparam logic [ADDR_W-1:0] CODE_DIR  = 4'd15;

  typedef enum logic [2:0] {
    CMD_DAC  = 3'd0,
    CMD_PWR  = 3'd1,
    CMD_PRD  = 3'd2,
    CMD_DIR  = 3'd3,
    CMD_NOP  = 3'd4
  } cmd_e;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {(STAGES*W){RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             sen_ns_i,
  output logic             shift_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclk_q, sen_nq;
  logic [CNT_W-1:0] cnt_q;
  logic sclk_rise, en_fall, en_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sen_nq <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      sen_nq <= sen_ns_i;
    end
  end

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign en_fall   = ~sen_ns_i & sen_nq;
  assign en_rise   = sen_ns_i & ~sen_nq;
  assign shift_o   = sclk_rise & ~sen_ns_i;
  assign done_o    = en_rise & (cnt_q == CNT_FULL);

  // counter saturates past a full frame so overlong frames stay invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (en_fall || en_rise)      cnt_q <= '0;
    else if (shift_o && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift
  import sfr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  input  logic               preload_i,
  input  logic [DATA_W-1:0]  par_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (shift_i)   sr_q <= {bit_i, sr_q[FRAME_W-1:1]};
    else if (preload_i) sr_q <= {par_i, sr_q[ADDR_W-1:0]};
  end

  assign word_o = sr_q;
  assign sdo_o  = sr_q[0];
endmodule

// File: rtl/sfr_decode.sv
module sfr_decode
  import sfr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               preload_o,
  output logic               load_o,
  output logic [2:0]         cmd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);
  logic [ADDR_W-1:0] addr;
  cmd_e cmd;

  assign addr = word_i[ADDR_W-1:0];

  always_comb begin
    if (int'(addr) < NUM_DAC) cmd = CMD_DAC;
    else begin
      unique case (addr)
        CODE_PWR: cmd = CMD_PWR;
        CODE_PRD: cmd = CMD_PRD;
        CODE_DIR: cmd = CMD_DIR;
        default:  cmd = CMD_NOP;
      endcase
    end
  end

  assign preload_o = done_i & (cmd == CMD_PRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= 1'b0;
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      load_o <= done_i & (cmd != CMD_NOP);
      if (done_i && cmd != CMD_NOP) begin
        cmd_o  <= cmd;
        addr_o <= addr;
        data_o <= word_i[FRAME_W-1:ADDR_W];
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              sclk_i,
  input  logic              sen_ni,
  input  logic [DATA_W-1:0] par_i,
  output logic              sdo_o,
  output logic              load_o,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic sdi_s, sclk_s, sen_ns;
  logic shift_ev, done_ev, preload_ev;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] word;

  sfr_sync #(.W(2), .STAGES(2), .RST_VAL(1'b0)) u_sync_lo (
    .clk_i, .rst_ni, .d_i({sdi_i, sclk_i}), .q_o({sdi_s, sclk_s})
  );
  sfr_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_sync_en (
    .clk_i, .rst_ni, .d_i(sen_ni), .q_o(sen_ns)
  );

  sfr_frame_ctrl u_ctrl (
    .clk_i, .rst_ni, .sclk_s_i(sclk_s), .sen_ns_i(sen_ns),
    .shift_o(shift_ev), .done_o(done_ev), .cnt_o(bit_cnt)
  );

  sfr_shift u_shift (
    .clk_i, .rst_ni, .shift_i(shift_ev), .bit_i(sdi_s),
    .preload_i(preload_ev), .par_i, .word_o(word), .sdo_o
  );

  sfr_decode u_dec (
    .clk_i, .rst_ni, .done_i(done_ev), .word_i(word),
    .preload_o(preload_ev), .load_o, .cmd_o, .addr_o, .data_o
  );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk
  import sfr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_ev,
  input logic             preload_ev,
  input logic             done_ev,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             load_o,
  input logic [2:0]       cmd_o,
  input logic             sdo_o
);
  assert_load_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  assert_no_nop_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> cmd_o != CMD_NOP);
  assert_load_after_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> $past(done_ev));
  assert_sdo_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_ev && !preload_ev) |=> $stable(sdo_o));
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W + 1));
  assert_cmd_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> cmd_o <= 3'd3);
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .shift_ev(shift_ev), .preload_ev(preload_ev),
  .done_ev(done_ev), .bit_cnt(bit_cnt), .load_o(load_o), .cmd_o(cmd_o), .sdo_o(sdo_o)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, sclk = 1'b0, sen_n = 1'b1;
  logic [11:0] par = '0;
  logic sdo, load;
  logic [2:0] cmd;
  logic [3:0] addr;
  logic [11:0] data;

  int total = 0, bad = 0;
  logic [18:0] exp_q[$];
  logic [15:0] model;

  always #5 clk = ~clk;

  serial_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdi_i(sdi), .sclk_i(sclk), .sen_ni(sen_n),
    .par_i(par), .sdo_o(sdo), .load_o(load), .cmd_o(cmd), .addr_o(addr), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pop one expected item per strobe, check strobe width (R10)
  always @(negedge clk) begin
    if (rst_n && load) begin
      if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected load", {13'd0, cmd, addr, data}, 32'd0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk({cmd, addr, data} == e, "R3/R4 load fields", {13'd0, cmd, addr, data}, {13'd0, e});
      end
      @(negedge clk);
      chk(!load, "R10 single-cycle strobe", {31'd0, load}, 32'd0);
    end
  end

  function automatic logic [2:0] exp_cmd(input logic [3:0] a);
    if (a < 4'd12) return 3'd0;
    if (a == 4'd13) return 3'd1;
    if (a == 4'd14) return 3'd2;
    if (a == 4'd15) return 3'd3;
    return 3'd4;
  endfunction

  task automatic send(input logic [31:0] w, input int n, input string req);
    logic [31:0] obs = '0;
    logic [15:0] pre = model;
    sen_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = w[i];
      repeat (4) @(posedge clk);
      @(negedge clk);
      obs[i] = sdo;
      sclk = 1'b1;
      model = {w[i], model[15:1]};
      repeat (4) @(posedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(posedge clk);
    for (int i = 0; i < 16 && i < n; i++)
      chk(obs[i] == pre[i], req, {31'd0, obs[i]}, {31'd0, pre[i]});
    if (n == 16 && exp_cmd(w[3:0]) != 3'd4)
      exp_q.push_back({exp_cmd(w[3:0]), w[3:0], w[15:4]});
    if (n == 16 && w[3:0] == 4'd14) model[15:4] = par;
    sen_n = 1'b1;
    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0, "R3/R5/R6 strobe count", exp_q.size(), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
      end
    join_none
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(load == 1'b0, "R1 load after reset", {31'd0, load}, 32'd0);
    chk(sdo == 1'b0, "R1 sdo after reset", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    send(32'hA5C3, 16, "R2 R7 sdo readout");
    send(32'h123B, 16, "R7 chained bits");
    send(32'hFFF0, 16, "R7 sdo");
    send(32'h0ABD, 16, "R4 port write");
    send(32'h555F, 16, "R4 direction");
    send(32'h7E1C, 16, "R5 nop frame");
    send(32'h0345, 10, "R6 short frame");
    send(32'h0F0F1, 20, "R6 long frame");
    send(32'h9876, 16, "R6 recovery");
    par = 12'hC3A;
    send(32'hBEEE, 16, "R8 capture cmd");
    par = 12'h000;
    send(32'h2461, 16, "R8 capture readback");
    // R9: stray shift edges with enable high
    for (int i = 0; i < 5; i++) begin
      sdi = ~sdi;
      repeat (4) @(posedge clk);
      sclk = 1'b1;
      repeat (4) @(posedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(sdo == model[0], "R9 sdo unchanged", {31'd0, sdo}, {31'd0, model[0]});
    send(32'h1357, 16, "R9 register intact");
    send(32'hFFFB, 16, "R4 last DAC code");
    send(32'h0000, 16, "R4 first DAC code");
    finish_run();
  end
endmodule